// File: doc/BRIEF.md
# Decode-Stage Zero-Test Branch Resolver with Nullifying Delay Slot

This block sits in the decode stage of a five-stage in-order pipeline. It decides conditional branches there, so the fetch stage never waits for the execute or memory stage. The two branch kinds it handles compare one source register against zero. One branch jumps when the register is zero and the other jumps when it is non-zero. A private adder forms the jump address from the branch's own PC+4 and its word offset. The block also presents the sequential address that follows the delay slot. The main ALU is never used for any of this.

Exactly one instruction, the delay slot, follows every branch, and it normally runs whatever the outcome. A branch can set its cancel bit. It then also carries a static taken/not-taken guess. When the real outcome differs from that guess, the slot instruction is nullified: its register-write and memory-write controls are cleared as it passes from decode into execute.

An interlock covers the case where the instruction now in execute writes the branch's source register. The branch holds in decode for one cycle and resolves in the following cycle, once the value can be forwarded.

A four-state controller drives all of this:
- `ST_DECODE` is the normal decode state.
- `ST_HOLD` is the one-cycle interlock wait.
- `ST_SLOT_KEEP` marks a delay slot that runs normally.
- `ST_SLOT_KILL` marks a delay slot that is nullified.

The controller makes these transitions:
- From `ST_DECODE` to `ST_HOLD` when a branch meets a hazard.
- From `ST_DECODE` or `ST_HOLD` to `ST_SLOT_KEEP` or `ST_SLOT_KILL` when a branch resolves.
- From either slot state back to `ST_DECODE` after one cycle.
- From `ST_DECODE` to itself for any other instruction.

Top module: `branch_resolve_id`

## Requirements
- R1: The instruction word is decoded as follows:
  - opcode in bits [31:26], where 6'h04 is the branch-if-zero and 6'h05 is the branch-if-non-zero;
  - source register index in bits [25:21];
  - cancel bit in bit 20;
  - predict-taken bit in bit 19;
  - signed word offset in bits [15:0].

  Any other opcode, or `id_valid` low, never resolves a branch.
- R2: In its resolving cycle, branch-if-zero drives `pc_sel` high exactly when `id_rs_val` is zero. Branch-if-non-zero drives it high exactly when `id_rs_val` is non-zero. `pc_sel` is low in every cycle where no branch resolves.
- R3: `br_target` equals `id_pc4` plus the sign-extended offset shifted left by two. `fall_pc` equals `id_pc4` plus 4.
- R4: A branch with no hazard resolves in the same cycle it is first presented in decode, with `stall` low.
- R5: A branch whose source register is nonzero and equals `ex_dst` while `ex_reg_we` is high raises `stall` for exactly one cycle, with `br_resolve` low. It resolves in the next cycle.
- R6: No interlock occurs when the source register is 0 or when `ex_reg_we` is low.
- R7: A branch with the cancel bit clear never causes a squash of its delay slot.
- R8: For a branch with the cancel bit set, `squash` is high during the next cycle (the slot's decode cycle) exactly when the outcome differs from the predict-taken bit.
- R9: `idex_reg_we` and `idex_mem_we` follow `id_reg_we` and `id_mem_we`, except that both are low while `squash` or `stall` is high.
- R10: A branch opcode presented in the delay-slot cycle is not resolved: `br_resolve` and `pc_sel` stay low.
- R11: After reset, `stall`, `squash`, `br_resolve` and `pc_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_pc4 | input | 32 | PC+4 of the decode instruction |
| id_rs_val | input | 32 | Forwarded source register value |
| id_reg_we | input | 1 | Decoded register-write control of the decode instruction |
| id_mem_we | input | 1 | Decoded memory-write control of the decode instruction |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_reg_we | input | 1 | Execute-stage instruction writes a register |
| pc_sel | output | 1 | Select the branch target as next fetch address |
| br_target | output | 32 | Computed jump address |
| fall_pc | output | 32 | Sequential address after the delay slot |
| br_resolve | output | 1 | A branch is decided this cycle |
| stall | output | 1 | Hold fetch and decode for the interlock |
| squash | output | 1 | Nullify the delay-slot instruction now in decode |
| idex_reg_we | output | 1 | Register-write control passed into execute |
| idex_mem_we | output | 1 | Memory-write control passed into execute |

## Verification
Zero and non-zero operands are applied to both branch kinds, which separates the two senses of the zero test. Positive and negative offsets show whether the sign extension and the shift are right. Each branch is followed by a slot that carries both write controls set, and this is done for:
- non-canceling branches;
- canceling branches whose guess matches the outcome;
- canceling branches whose guess misses the outcome.

This distinguishes a nullified slot from a kept one. Hazard patterns vary the register index, the execute write flag and register 0. They show whether the interlock fires only on a real dependence and holds the branch for exactly one cycle. A branch opcode placed in the slot shows that the slot is never taken for a new branch.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int OPW       = 6;
    localparam int RIDX      = 5;
    localparam int OFFW      = 16;
    localparam logic [OPW-1:0] OP_BR_ZERO    = 6'h04;
    localparam logic [OPW-1:0] OP_BR_NONZERO = 6'h05;

    // bit positions inside the instruction word
    localparam int OP_LSB     = 26;
    localparam int RS_LSB     = 21;
    localparam int CANCEL_BIT = 20;
    localparam int PRED_BIT   = 19;

    typedef enum logic [1:0] {
        ST_DECODE    = 2'd0,
        ST_HOLD      = 2'd1,
        ST_SLOT_KEEP = 2'd2,
        ST_SLOT_KILL = 2'd3
    } br_state_e;

    typedef struct packed {
        logic            is_br;
        logic            is_zero_test;
        logic [RIDX-1:0] rs;
        logic            cancel;
        logic            pred;
        logic [OFFW-1:0] off;
    } br_fields_t;
endpackage

// File: rtl/br_field_decode.sv
module br_field_decode
    import br_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit ZERO_HARD = 1'b1
) (
    input  logic            valid_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [RIDX-1:0] ex_dst_i,
    input  logic            ex_we_i,
    output br_fields_t      fld_o,
    output logic            hazard_o
);
    logic [OPW-1:0] opcode;
    logic           dep;

    always_comb begin
        opcode              = instr_i[OP_LSB +: OPW];
        fld_o.is_br         = valid_i && (opcode == OP_BR_ZERO || opcode == OP_BR_NONZERO);
        fld_o.is_zero_test  = (opcode == OP_BR_ZERO);
        fld_o.rs            = instr_i[RS_LSB +: RIDX];
        fld_o.cancel        = instr_i[CANCEL_BIT];
        fld_o.pred          = instr_i[PRED_BIT];
        fld_o.off           = instr_i[OFFW-1:0];
    end

    generate
        if (ZERO_HARD) begin : g_r0_const
            assign dep = ex_we_i && (ex_dst_i == fld_o.rs) && (fld_o.rs != '0);
        end else begin : g_r0_plain
            assign dep = ex_we_i && (ex_dst_i == fld_o.rs);
        end
    endgenerate

    assign hazard_o = fld_o.is_br && dep;
endmodule

// File: rtl/br_addr_calc.sv
module br_addr_calc
    import br_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int SHAMT = 2
) (
    input  logic [XLEN-1:0] pc4_i,
    input  logic [OFFW-1:0] off_i,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] fall_o
);
    localparam int EXTW = XLEN - OFFW - SHAMT;
    localparam logic [XLEN-1:0] SLOT_STEP = XLEN'(4);

    logic [XLEN-1:0] disp;

    assign disp     = {{EXTW{off_i[OFFW-1]}}, off_i, {SHAMT{1'b0}}};
    assign target_o = pc4_i + disp;
    assign fall_o   = pc4_i + SLOT_STEP;
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
    parameter int XLEN = 32,
    parameter int LANE = 8
) (
    input  logic [XLEN-1:0] val_i,
    input  logic            zero_test_i,
    output logic            taken_o
);
    localparam int NLANE = (XLEN + LANE - 1) / LANE;
    localparam int PADW  = NLANE * LANE;

    logic [PADW-1:0]  padded;
    logic [NLANE-1:0] lane_any;
    logic             is_zero;

    assign padded = PADW'(val_i);

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            assign lane_any[g] = |padded[g*LANE +: LANE];
        end
    endgenerate

    assign is_zero = ~|lane_any;
    assign taken_o = zero_test_i ? is_zero : ~is_zero;
endmodule

// File: rtl/br_slot_fsm.sv
module br_slot_fsm
    import br_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_br_i,
    input  logic hazard_i,
    input  logic taken_i,
    input  logic cancel_i,
    input  logic pred_i,
    output logic stall_o,
    output logic resolve_o,
    output logic squash_o
);
    br_state_e state_q, state_d;
    logic      miss;

    assign miss = cancel_i && (taken_i != pred_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DECODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        stall_o   = 1'b0;
        resolve_o = 1'b0;
        squash_o  = 1'b0;
        unique case (state_q)
            ST_DECODE: begin
                if (is_br_i && hazard_i) begin
                    stall_o = 1'b1;
                    state_d = ST_HOLD;
                end else if (is_br_i) begin
                    resolve_o = 1'b1;
                    state_d   = miss ? ST_SLOT_KILL : ST_SLOT_KEEP;
                end
            end
            ST_HOLD: begin
                if (is_br_i) begin
                    resolve_o = 1'b1;
                    state_d   = miss ? ST_SLOT_KILL : ST_SLOT_KEEP;
                end else begin
                    state_d = ST_DECODE;
                end
            end
            ST_SLOT_KEEP: state_d = ST_DECODE;
            ST_SLOT_KILL: begin
                squash_o = 1'b1;
                state_d  = ST_DECODE;
            end
        endcase
    end

    // R5
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);
    // R5
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stall_o, resolve_o, squash_o}));
    // R8
    cancel_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_o && miss) |=> squash_o);
    // R7
    no_cancel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_o && !cancel_i) |=> !squash_o);
    // R10
    slot_no_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_o |=> !resolve_o);
endmodule

// File: rtl/branch_resolve_id.sv
module branch_resolve_id
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [XLEN-1:0] id_instr,
    input  logic [XLEN-1:0] id_pc4,
    input  logic [XLEN-1:0] id_rs_val,
    input  logic            id_reg_we,
    input  logic            id_mem_we,
    input  logic [RIDX-1:0] ex_dst,
    input  logic            ex_reg_we,
    output logic            pc_sel,
    output logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] fall_pc,
    output logic            br_resolve,
    output logic            stall,
    output logic            squash,
    output logic            idex_reg_we,
    output logic            idex_mem_we
);
    br_fields_t fld;
    logic       hazard;
    logic       taken;

    br_field_decode #(.XLEN(XLEN), .ZERO_HARD(1'b1)) u_dec (
        .valid_i  (id_valid),
        .instr_i  (id_instr),
        .ex_dst_i (ex_dst),
        .ex_we_i  (ex_reg_we),
        .fld_o    (fld),
        .hazard_o (hazard)
    );

    br_addr_calc #(.XLEN(XLEN), .SHAMT(2)) u_adder (
        .pc4_i    (id_pc4),
        .off_i    (fld.off),
        .target_o (br_target),
        .fall_o   (fall_pc)
    );

    br_cond_eval #(.XLEN(XLEN), .LANE(8)) u_cond (
        .val_i       (id_rs_val),
        .zero_test_i (fld.is_zero_test),
        .taken_o     (taken)
    );

    br_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_br_i   (fld.is_br),
        .hazard_i  (hazard),
        .taken_i   (taken),
        .cancel_i  (fld.cancel),
        .pred_i    (fld.pred),
        .stall_o   (stall),
        .resolve_o (br_resolve),
        .squash_o  (squash)
    );

    assign pc_sel      = br_resolve && taken;
    assign idex_reg_we = id_reg_we && !squash && !stall;
    assign idex_mem_we = id_mem_we && !squash && !stall;

    // R9
    squash_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> (!idex_reg_we && !idex_mem_we));
    // R2
    sel_needs_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel |-> br_resolve);
endmodule

// File: tb/branch_resolve_id_bench.sv
module branch_resolve_id_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic [31:0] id_instr = '0;
    logic [31:0] id_pc4 = '0;
    logic [31:0] id_rs_val = '0;
    logic        id_reg_we = 1'b0;
    logic        id_mem_we = 1'b0;
    logic [4:0]  ex_dst = '0;
    logic        ex_reg_we = 1'b0;
    logic        pc_sel, br_resolve, stall, squash, idex_reg_we, idex_mem_we;
    logic [31:0] br_target, fall_pc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    branch_resolve_id u_branch_resolve_id (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
        .id_pc4(id_pc4), .id_rs_val(id_rs_val), .id_reg_we(id_reg_we),
        .id_mem_we(id_mem_we), .ex_dst(ex_dst), .ex_reg_we(ex_reg_we),
        .pc_sel(pc_sel), .br_target(br_target), .fall_pc(fall_pc),
        .br_resolve(br_resolve), .stall(stall), .squash(squash),
        .idex_reg_we(idex_reg_we), .idex_mem_we(idex_mem_we)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic cancel, input logic pred,
                                       input logic [15:0] off);
        return {op, rs, cancel, pred, 3'b000, off};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #2;
    endtask

    task automatic idle();
        id_valid = 1'b0; id_instr = '0; id_reg_we = 1'b0; id_mem_we = 1'b0;
        ex_reg_we = 1'b0; ex_dst = '0;
    endtask

    // present a branch, check resolution, then a slot carrying both writes
    task automatic branch_then_slot(input string tag, input logic [5:0] op,
                                    input logic cancel, input logic pred,
                                    input logic [31:0] rsv, input logic [15:0] off,
                                    input logic [31:0] pc4, input logic exp_take,
                                    input logic exp_squash);
        logic [31:0] disp;
        disp = {{14{off[15]}}, off, 2'b00};
        id_valid = 1'b1; id_instr = mk(op, 5'd3, cancel, pred, off);
        id_pc4 = pc4; id_rs_val = rsv; id_reg_we = 1'b0; id_mem_we = 1'b0;
        #2;
        check({tag, " R4 resolve"}, 32'(br_resolve), 32'(1));
        check({tag, " R4 stall"}, 32'(stall), 32'(0));
        check({tag, " R2 pc_sel"}, 32'(pc_sel), 32'(exp_take));
        check({tag, " R3 target"}, br_target, pc4 + disp);
        check({tag, " R3 fall"}, fall_pc, pc4 + 32'd4);
        next_cycle();
        id_instr = mk(6'h08, 5'd1, 1'b0, 1'b0, 16'h0001);
        id_pc4 = pc4 + 32'd4; id_reg_we = 1'b1; id_mem_we = 1'b1;
        #1;
        check({tag, " R8 squash"}, 32'(squash), 32'(exp_squash));
        check({tag, " R9 reg_we"}, 32'(idex_reg_we), 32'(!exp_squash));
        check({tag, " R9 mem_we"}, 32'(idex_mem_we), 32'(!exp_squash));
        next_cycle();
        idle();
        #1;
    endtask

    task automatic t_reset();
        #1;
        check("R11 stall", 32'(stall), 32'(0));
        check("R11 squash", 32'(squash), 32'(0));
        check("R11 resolve", 32'(br_resolve), 32'(0));
        check("R11 pc_sel", 32'(pc_sel), 32'(0));
    endtask

    task automatic t_basic();
        branch_then_slot("zero-taken", 6'h04, 1'b0, 1'b0, 32'd0, 16'h0010, 32'h0000_1000, 1'b1, 1'b0);
        branch_then_slot("zero-fall", 6'h04, 1'b0, 1'b1, 32'h0000_0100, 16'h0010, 32'h0000_2000, 1'b0, 1'b0);
        branch_then_slot("nz-back", 6'h05, 1'b0, 1'b0, 32'h8000_0000, 16'hFFF0, 32'h0000_3000, 1'b1, 1'b0);
        branch_then_slot("nz-fall", 6'h05, 1'b0, 1'b1, 32'd0, 16'h7FFF, 32'h0000_4000, 1'b0, 1'b0);
    endtask

    task automatic t_cancel();
        branch_then_slot("R7 plain-miss", 6'h04, 1'b0, 1'b1, 32'd5, 16'h0004, 32'h100, 1'b0, 1'b0);
        branch_then_slot("R8 hit-taken", 6'h04, 1'b1, 1'b1, 32'd0, 16'h0004, 32'h200, 1'b1, 1'b0);
        branch_then_slot("R8 hit-fall", 6'h05, 1'b1, 1'b0, 32'd0, 16'h0004, 32'h300, 1'b0, 1'b0);
        branch_then_slot("R8 miss-fall", 6'h04, 1'b1, 1'b1, 32'd9, 16'h0004, 32'h400, 1'b0, 1'b1);
        branch_then_slot("R8 miss-taken", 6'h05, 1'b1, 1'b0, 32'd9, 16'hFFFC, 32'h500, 1'b1, 1'b1);
    endtask

    task automatic t_hazard();
        id_valid = 1'b1; id_instr = mk(6'h05, 5'd3, 1'b0, 1'b0, 16'h0008);
        id_pc4 = 32'h600; id_rs_val = 32'd0; ex_dst = 5'd3; ex_reg_we = 1'b1;
        #2;
        check("R5 stall on dep", 32'(stall), 32'(1));
        check("R5 no resolve in stall", 32'(br_resolve), 32'(0));
        next_cycle();
        ex_reg_we = 1'b0; id_rs_val = 32'd7;
        #1;
        check("R5 stall released", 32'(stall), 32'(0));
        check("R5 resolve after stall", 32'(br_resolve), 32'(1));
        check("R5 pc_sel after stall", 32'(pc_sel), 32'(1));
        next_cycle();
        idle();
        next_cycle();
        // register 0 never interlocks
        id_valid = 1'b1; id_instr = mk(6'h04, 5'd0, 1'b0, 1'b0, 16'h0008);
        id_rs_val = 32'd0; ex_dst = 5'd0; ex_reg_we = 1'b1;
        #2;
        check("R6 reg0 no stall", 32'(stall), 32'(0));
        check("R6 reg0 resolves", 32'(br_resolve), 32'(1));
        next_cycle();
        idle();
        next_cycle();
        // matching index but no write
        id_valid = 1'b1; id_instr = mk(6'h04, 5'd3, 1'b0, 1'b0, 16'h0008);
        ex_dst = 5'd3; ex_reg_we = 1'b0;
        #2;
        check("R6 no write no stall", 32'(stall), 32'(0));
        next_cycle();
        idle();
        next_cycle();
        // different register
        id_valid = 1'b1; id_instr = mk(6'h04, 5'd3, 1'b0, 1'b0, 16'h0008);
        ex_dst = 5'd4; ex_reg_we = 1'b1;
        #2;
        check("R6 other reg no stall", 32'(stall), 32'(0));
        next_cycle();
        idle();
        next_cycle();
        // stall gates write controls
        id_valid = 1'b1; id_instr = mk(6'h04, 5'd3, 1'b0, 1'b0, 16'h0008);
        ex_dst = 5'd3; ex_reg_we = 1'b1; id_reg_we = 1'b1; id_mem_we = 1'b1;
        #2;
        check("R9 stall gates reg_we", 32'(idex_reg_we), 32'(0));
        next_cycle();
        ex_reg_we = 1'b0;
        next_cycle();
        idle();
        next_cycle();
    endtask

    task automatic t_slot_branch();
        id_valid = 1'b1; id_instr = mk(6'h04, 5'd0, 1'b0, 1'b0, 16'h0020);
        id_rs_val = 32'd0; id_pc4 = 32'h700;
        #2;
        check("R10 first branch", 32'(pc_sel), 32'(1));
        next_cycle();
        id_instr = mk(6'h04, 5'd0, 1'b0, 1'b0, 16'h0040);
        #1;
        check("R10 slot branch resolve", 32'(br_resolve), 32'(0));
        check("R10 slot branch pc_sel", 32'(pc_sel), 32'(0));
        next_cycle();
        idle();
        next_cycle();
    endtask

    task automatic t_non_branch();
        id_valid = 1'b1; id_instr = mk(6'h06, 5'd0, 1'b0, 1'b0, 16'h0020);
        id_rs_val = 32'd0; id_reg_we = 1'b1; id_mem_we = 1'b0;
        #2;
        check("R1 other opcode", 32'(br_resolve), 32'(0));
        check("R9 pass reg_we", 32'(idex_reg_we), 32'(1));
        id_instr = mk(6'h04, 5'd0, 1'b0, 1'b0, 16'h0020); id_valid = 1'b0;
        #1;
        check("R1 invalid slot", 32'(br_resolve), 32'(0));
        next_cycle();
        idle();
        next_cycle();
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        next_cycle();
        t_reset();
        t_basic();
        t_cancel();
        t_hazard();
        t_slot_branch();
        t_non_branch();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule